// File: doc/BRIEF.md
# Write-Triggered Interrupt Receiver

This block is a bus slave that turns ordinary write transactions into
interrupt lines for a processor core that only has interrupt input pins.
Whoever needs to interrupt the core issues a single write to this slave.
No dedicated interrupt wire runs from that sender. The word offset of the
write picks the interrupt line, and the write data travels with the event as
a payload. The core reads that payload from a dedicated output.

Every write is a separate event. Accepted events wait in a small first-in
first-out queue. Only the oldest pending event drives its line, one-hot. The
core retires events one at a time with a single-cycle pop strobe. It can
therefore service one event and leave later ones pending. There are no mask
or enable registers. When the core stops retiring events and the queue fills,
the slave raises its pipelined-bus stall. Senders are then held off, and
acknowledges stop without any further control logic.

Top module: `msi_irq_unit`

## Requirements
- R1: A transfer is accepted in a cycle where `wb_cyc`, `wb_stb` are high and `wb_stall` is low; `wb_ack` is high for exactly one cycle, the cycle right after each acceptance, and low otherwise.
- R2: An accepted write with word offset `wb_adr` = k, where k < LINES (default 12), queues one event holding line index k and the write data.
- R3: `irq_line` is the one-hot code of the head event's line index (bit k high for index k) while the queue holds an event, and all zeros while it is empty; `head_valid` is high exactly when the queue holds an event.
- R4: Events leave in the order they were accepted, and `head_data` shows the write data of the head event.
- R5: A high `pop` removes the head event in that cycle; a pop while the queue is empty has no effect.
- R6: A push and an effective pop in the same cycle leave the number of pending events unchanged, with the new event placed behind the remaining ones.
- R7: The queue holds DEPTH (default 8) events; `wb_stall` is high exactly while DEPTH events are pending, and a strobe during stall is neither accepted nor acknowledged.
- R8: An accepted write with offset k >= LINES is acknowledged and discarded: nothing is queued.
- R9: An accepted strobe with `wb_we` low is acknowledged and queues nothing.
- R10: While `rst_n` is low at a clock edge the queue is emptied; after it, `irq_line` is zero, `head_valid`, `wb_stall` and `wb_ack` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wb_cyc | input | 1 | Bus cycle in progress |
| wb_stb | input | 1 | Transfer strobe |
| wb_we | input | 1 | Write enable |
| wb_adr | input | ADR_W (8) | Word offset of the transfer |
| wb_dat_w | input | DATA_W (32) | Write data, carried as event payload |
| wb_ack | output | 1 | Transfer acknowledge, one cycle after acceptance |
| wb_stall | output | 1 | Queue full, transfer not taken |
| pop | input | 1 | Retire the head event |
| head_valid | output | 1 | At least one event pending |
| head_data | output | DATA_W (32) | Payload of the head event |
| irq_line | output | LINES (12) | One-hot interrupt line of the head event |

## Verification
The hardest situation to reach from the ports is a full queue meeting a
simultaneous strobe and pop. In that cycle the stall must reject the write
even though a slot frees at the same edge. The bench reaches it by holding
`pop` low through a run of writes until stall rises. It then drives writes
together with pops at every occupancy from empty to full. A bench queue model
computed from the requirements tracks the ordering, occupancy and stall
through these cycles. A full sweep of all 256 offsets covers the boundary
between queued and discarded writes.

// File: rtl/msi_pkg.sv
// Package: shared widths and the queued event type.
// Assumes the line index width covers every implemented line.
package msi_pkg;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 4;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } irq_event_t;
endpackage

// File: rtl/msi_bus_front.sv
// Bus front end: takes transfers when not stalled, acknowledges each one a
// cycle later, and turns in-range writes into queue pushes.
// Assumes LINES <= 2**IDX_W so the low offset bits form the line index.
module msi_bus_front #(
    parameter int ADR_W = 8,
    parameter int LINES = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wb_cyc,
    input  logic                      wb_stb,
    input  logic                      wb_we,
    input  logic [ADR_W-1:0]          wb_adr,
    input  logic [msi_pkg::DATA_W-1:0] wb_dat_w,
    input  logic                      q_full,
    output logic                      wb_ack,
    output logic                      wb_stall,
    output logic                      push,
    output msi_pkg::irq_event_t       push_evt
);
    import msi_pkg::*;

    localparam logic [ADR_W-1:0] LINES_A = ADR_W'(LINES);

    logic accept;
    logic in_range;

    // Stall purely reflects a full queue.
    always_comb wb_stall = q_full;

    // Acceptance and decode of the write offset.
    always_comb begin
        accept       = wb_cyc && wb_stb && !q_full;
        in_range     = (wb_adr < LINES_A);
        push         = accept && wb_we && in_range;
        push_evt.idx  = wb_adr[IDX_W-1:0];
        push_evt.data = wb_dat_w;
    end

    // Acknowledge register: one pulse per accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) wb_ack <= 1'b0;
        else        wb_ack <= accept;
    end

    assert_ack_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc && wb_stb && !wb_stall) |=> wb_ack);
    assert_ack_needs_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |-> $past(wb_cyc && wb_stb && !wb_stall));
    assert_stall_blocks_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stall |-> !push);
endmodule

// File: rtl/msi_event_fifo.sv
// Event queue: ring buffer of DEPTH events with occupancy count.
// Assumes DEPTH is a power of two and that push never arrives while full.
module msi_event_fifo #(
    parameter int DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push,
    input  msi_pkg::irq_event_t push_evt,
    input  logic                pop,
    output logic                full,
    output logic                valid,
    output msi_pkg::irq_event_t head_evt
);
    import msi_pkg::*;

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    irq_event_t       slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_pop;

    // Status flags and effective pop.
    always_comb begin
        valid    = (count != '0);
        full     = (count == DEPTH_C);
        do_pop   = pop && valid;
        head_evt = slots[rd_ptr];
    end

    // Slot storage: written at the write pointer on push.
    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_evt;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)   wr_ptr <= wr_ptr + 1'b1;
            if (do_pop) rd_ptr <= rd_ptr + 1'b1;
            case ({push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= DEPTH_C);
    assert_pushpop_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && valid) |=> $stable(count));
    assert_empty_pop_noop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !valid && !push) |=> !valid);
endmodule

// File: rtl/msi_line_drive.sv
// Line driver: decodes the head event's index into one-hot interrupt lines.
// Assumes the index is only meaningful while the queue is non-empty.
module msi_line_drive #(
    parameter int LINES = 12
) (
    input  logic                         valid,
    input  logic [msi_pkg::IDX_W-1:0]    idx,
    output logic [LINES-1:0]             irq_line
);
    import msi_pkg::*;

    // One comparator per implemented line.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        always_comb irq_line[g] = valid && (idx == MY_IDX);
    end

    always_comb begin
        assert_lines_onehot_R3: assert ($onehot0(irq_line));
    end
endmodule

// File: rtl/msi_irq_unit.sv
// Top: write-triggered interrupt receiver. Bus writes become queued events
// whose head drives a one-hot interrupt line until popped.
// Assumes the consumer pops only after servicing the head event.
module msi_irq_unit #(
    parameter int ADR_W = 8,
    parameter int LINES = 12,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wb_cyc,
    input  logic                       wb_stb,
    input  logic                       wb_we,
    input  logic [ADR_W-1:0]           wb_adr,
    input  logic [msi_pkg::DATA_W-1:0] wb_dat_w,
    output logic                       wb_ack,
    output logic                       wb_stall,
    input  logic                       pop,
    output logic                       head_valid,
    output logic [msi_pkg::DATA_W-1:0] head_data,
    output logic [LINES-1:0]           irq_line
);
    import msi_pkg::*;

    logic       q_full;
    logic       push;
    irq_event_t push_evt;
    irq_event_t head_evt;

    msi_bus_front #(.ADR_W(ADR_W), .LINES(LINES)) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .wb_cyc   (wb_cyc),
        .wb_stb   (wb_stb),
        .wb_we    (wb_we),
        .wb_adr   (wb_adr),
        .wb_dat_w (wb_dat_w),
        .q_full   (q_full),
        .wb_ack   (wb_ack),
        .wb_stall (wb_stall),
        .push     (push),
        .push_evt (push_evt)
    );

    msi_event_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_evt (push_evt),
        .pop      (pop),
        .full     (q_full),
        .valid    (head_valid),
        .head_evt (head_evt)
    );

    msi_line_drive #(.LINES(LINES)) u_lines (
        .valid    (head_valid),
        .idx      (head_evt.idx),
        .irq_line (irq_line)
    );

    // Payload of the head event.
    always_comb head_data = head_evt.data;

    assert_line_tracks_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        head_valid == (irq_line != '0));
    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |=> (!head_valid && !wb_stall && !wb_ack));
endmodule

// File: tb/tb_msi_irq_unit.sv
module tb_msi_irq_unit;
    localparam int CLK_PERIOD = 10;
    localparam int LINES = 12;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0, pop = 1'b0;
    logic [7:0]  wb_adr = '0;
    logic [31:0] wb_dat_w = '0;
    logic        wb_ack, wb_stall, head_valid;
    logic [31:0] head_data;
    logic [LINES-1:0] irq_line;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Bench queue model built from the requirements.
    int          m_idx [16];
    logic [31:0] m_dat [16];
    int          m_cnt = 0;

    msi_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .wb_cyc(wb_cyc), .wb_stb(wb_stb),
        .wb_we(wb_we), .wb_adr(wb_adr), .wb_dat_w(wb_dat_w),
        .wb_ack(wb_ack), .wb_stall(wb_stall), .pop(pop),
        .head_valid(head_valid), .head_data(head_data), .irq_line(irq_line)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input logic exp_ack);
        logic [LINES-1:0] exp_line;
        exp_line = '0;
        if (m_cnt > 0) exp_line[m_idx[0]] = 1'b1;
        chk(wb_ack == exp_ack, "R1 ack", 32'(wb_ack), 32'(exp_ack));
        chk(head_valid == (m_cnt > 0), "R3 head_valid", 32'(head_valid), 32'(m_cnt > 0));
        chk(irq_line == exp_line, "R3 irq_line", 32'(irq_line), 32'(exp_line));
        if (m_cnt > 0)
            chk(head_data == m_dat[0], "R4 head_data", head_data, m_dat[0]);
        chk(wb_stall == (m_cnt == DEPTH), "R7 stall", 32'(wb_stall), 32'(m_cnt == DEPTH));
    endtask

    // One bus cycle: drive at negedge, model the edge, check after it.
    task automatic step(input logic c, input logic s, input logic w,
                        input logic [7:0] a, input logic [31:0] d, input logic p);
        logic acc;
        @(negedge clk);
        wb_cyc = c; wb_stb = s; wb_we = w; wb_adr = a; wb_dat_w = d; pop = p;
        #1;
        chk(wb_stall == (m_cnt == DEPTH), "R7 stall before edge", 32'(wb_stall), 32'(m_cnt == DEPTH));
        acc = c && s && (m_cnt != DEPTH);
        @(posedge clk);
        if (p && m_cnt > 0) begin
            for (int i = 0; i < 15; i++) begin
                m_idx[i] = m_idx[i+1];
                m_dat[i] = m_dat[i+1];
            end
            m_cnt--;
        end
        if (acc && w && a < 8'(LINES)) begin
            m_idx[m_cnt] = int'(a);
            m_dat[m_cnt] = d;
            m_cnt++;
        end
        #1;
        check_outputs(acc);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 8'h0, 32'h0, 0);
    endtask

    task automatic drain();
        while (m_cnt > 0) step(0, 0, 0, 8'h0, 32'h0, 1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R10: reset state.
        repeat (3) @(posedge clk);
        #1;
        check_outputs(1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R2, R8: sweep every offset, each write followed by a pop.
        for (int a = 0; a < 256; a++) begin
            step(1, 1, 1, 8'(a), 32'hA500_0000 + 32'(a * 7), 0);
            step(0, 0, 0, 8'h0, 32'h0, 1);
        end

        // R9: reads are acknowledged but queue nothing.
        for (int a = 0; a < LINES; a += 3) step(1, 1, 0, 8'(a), 32'hDEAD0000 + 32'(a), 0);
        // R1: strobe without cycle, cycle without strobe.
        step(0, 1, 1, 8'd2, 32'h11, 0);
        step(1, 0, 1, 8'd3, 32'h22, 0);
        chk(!head_valid, "R9 R1 nothing queued", 32'(head_valid), 32'h0);

        // R5: pops on empty queue have no effect.
        step(0, 0, 0, 8'h0, 32'h0, 1);
        step(0, 0, 0, 8'h0, 32'h0, 1);

        // R7, R4: fill past depth, stalled writes refused, drain in order.
        for (int i = 0; i < DEPTH + 3; i++)
            step(1, 1, 1, 8'((i * 5) % LINES), 32'h0C00_0000 + 32'(i), 0);
        chk(wb_stall == 1'b1, "R7 full stall", 32'(wb_stall), 32'h1);
        drain();
        step(0, 0, 0, 8'h0, 32'h0, 1);

        // R6: push plus pop at every occupancy, including full.
        for (int n = 0; n <= DEPTH; n++) begin
            for (int i = 0; i < n; i++)
                step(1, 1, 1, 8'((i + n) % LINES), 32'(n * 100 + i), 0);
            step(1, 1, 1, 8'((n * 3) % LINES), 32'hBEEF_0000 + 32'(n), 1);
            step(1, 1, 1, 8'(LINES - 1), 32'hF00D_0000 + 32'(n), 1);
            drain();
        end

        // Back-to-back writes with alternating pops and out-of-range mixes.
        for (int i = 0; i < 40; i++)
            step(1, 1, 1, 8'((i * 11) % 20), 32'h7700_0000 + 32'(i), 1'(i % 3 == 0));
        drain();

        // R10: reset in the middle of activity.
        for (int i = 0; i < 5; i++) step(1, 1, 1, 8'(i), 32'h5000 + 32'(i), 0);
        @(negedge clk);
        wb_cyc = 0; wb_stb = 0; pop = 0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        m_cnt = 0;
        check_outputs(1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        step(1, 1, 1, 8'd6, 32'h1234_5678, 0);
        drain();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule